// File: doc/BRIEF.md
# ADC Oversampling Accumulator with Result Shifter

This block sits behind a 12-bit analog-to-digital conversion engine. Each accepted conversion result is added into a 20-bit accumulator. Once a programmed number of consecutive samples has been summed, a right shift is applied to the total. The low 16 bits of the shifted total become a new result word. The number of samples per result is any power of two from 2 to 256. The shift is 0 to 8 bit positions. Sample timing does not change: the block simply emits one result per N accepted samples.

Both settings are captured when the first sample of a sequence arrives, so they can be changed at any time without corrupting a sequence in progress. Clearing or disabling the block discards a partial sum but leaves the last delivered result in place. Software-side handshaking is modelled by three signals:
- a read strobe that drops the result-valid flag;
- a sticky overflow flag, raised when a fresh result lands on one that was never read, and cleared by writing 1;
- an interrupt line that merges the end-of-conversion pulse and the overflow flag through separate enables.

Top module: `ovs_accum`

## Requirements
- R1: After reset, `result` is 0 and `result_valid`, `eoc_pulse`, `ovr_flag` and `irq` are all 0.
- R2: `ratio_sel` code k (0..7) selects N = 2^(k+1) samples per result: code 0 is 2x, code 4 is 32x, code 7 is 256x. The result is produced on the clock edge that accepts the Nth sample of the sequence, and no earlier.
- R3: The result is the low 16 bits of (sum of the N samples) shifted right by `shift_sel` (codes 0..8 give 0..8 bits). The accumulator holds 256 x 0xFFF without loss. At full-scale input: 32x with shift 0 gives 0xFFE0; 256x with shift 0 gives 0xFF00; 32x with shift 4 gives 0x1FFE; 256x with shift 8 gives 0x0FFF.
- R4: `shift_sel` codes 9..15 act as a shift of 8 bits.
- R5: `ratio_sel` and `shift_sel` are captured with the first sample of a sequence. Changes made during a sequence apply only from the next sequence.
- R6: When `clear` is high, or `enable` is low, the partial sum and the sample count are discarded and samples are ignored. `result` keeps its last value, and no `eoc_pulse` follows.
- R7: `result_valid` is set when a result is produced and is cleared by `rd_strobe`. If both happen on the same edge, the set wins.
- R8: `ovr_flag` is set when a result is produced while `result_valid` is already 1 and `rd_strobe` is low. It stays set until `ovr_clr` is 1, and setting takes priority over clearing.
- R9: `irq` is 1 exactly when (`eoc_pulse` and `eoc_ie`) or (`ovr_flag` and `ovr_ie`).
- R10: `eoc_pulse` is high for exactly one clock cycle: the cycle after the edge that produced the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Block enable; low discards the partial sequence |
| clear | input | 1 | Synchronous clear of the partial sequence |
| smp_valid | input | 1 | Conversion sample strobe |
| smp_data | input | 12 | Conversion sample |
| ratio_sel | input | 3 | Samples per result, 2^(code+1) |
| shift_sel | input | 4 | Right shift 0..8; codes above 8 act as 8 |
| rd_strobe | input | 1 | Result read; clears result-valid |
| ovr_clr | input | 1 | Write 1 to clear the overflow flag |
| eoc_ie | input | 1 | End-of-conversion interrupt enable |
| ovr_ie | input | 1 | Overflow interrupt enable |
| result | output | 16 | Last delivered result |
| result_valid | output | 1 | Unread result present |
| eoc_pulse | output | 1 | One-cycle end-of-conversion pulse |
| ovr_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt |

## Verification
Some properties are checked by the assertions on every cycle:
- the end-of-conversion pulse never lasts two cycles, and it always comes with a set valid flag;
- the result word changes only alongside that pulse, and no pulse follows a cycle in which the block was disabled;
- the valid and overflow flags change only for their stated causes;
- the interrupt is silent when both enables are off.

Other behaviour can only be shown by the bench's scenarios:
- the arithmetic value of each result across ratios, shifts and reserved shift codes;
- the exact sample count at which a result appears;
- capture of the settings at the start of a sequence;
- a clear in the middle of a sequence.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  localparam int OVS_SAMPLE_W  = 12;
  localparam int OVS_RESULT_W  = 16;
  localparam int OVS_RATIO_W   = 3;
  localparam int OVS_SHIFT_W   = 4;
  localparam int OVS_MAX_SHIFT = 8;

  typedef enum logic [OVS_RATIO_W-1:0] {
    OVS_X2   = 3'd0,
    OVS_X4   = 3'd1,
    OVS_X8   = 3'd2,
    OVS_X16  = 3'd3,
    OVS_X32  = 3'd4,
    OVS_X64  = 3'd5,
    OVS_X128 = 3'd6,
    OVS_X256 = 3'd7
  } ovs_ratio_e;
endpackage

// File: rtl/ovs_seq_ctrl.sv
module ovs_seq_ctrl #(
  parameter int RATIO_W = 3,
  parameter int SHIFT_W = 4,
  localparam int CNT_W  = 1 << RATIO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               clear,
  input  logic               smp_valid,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic [SHIFT_W-1:0] shift_in,
  output logic               take,
  output logic               first,
  output logic               last,
  output logic [SHIFT_W-1:0] shift_eff
);
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [RATIO_W-1:0] ratio_eff;
  logic               flush;

  // Index of the final sample: 2^(code+1) - 1
  function automatic logic [CNT_W-1:0] last_index(input logic [RATIO_W-1:0] code);
    logic [CNT_W-1:0] m;
    for (int i = 0; i < CNT_W; i++) m[i] = (i <= int'(code));
    return m;
  endfunction

  always_comb begin
    flush     = clear | ~enable;
    take      = smp_valid & enable & ~clear;
    first     = (cnt_q == '0);
    ratio_eff = first ? ratio_in : ratio_q;
    shift_eff = first ? shift_in : shift_q;
    last      = take & (cnt_q == last_index(ratio_eff));

    cnt_d   = cnt_q;
    ratio_d = ratio_q;
    shift_d = shift_q;
    if (flush) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = last ? '0 : cnt_q + CNT_W'(1);
      if (first) begin
        ratio_d = ratio_in;
        shift_d = shift_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      shift_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      shift_q <= shift_d;
    end
  end
endmodule

// File: rtl/ovs_accum_dp.sv
module ovs_accum_dp #(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                take,
  input  logic                first,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [ACC_W-1:0]    sum
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    sum   = (first ? '0 : acc_q) + ACC_W'(sample);
    acc_d = acc_q;
    if (flush)     acc_d = '0;
    else if (take) acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/ovs_shifter.sv
module ovs_shifter #(
  parameter int ACC_W     = 20,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8,
  parameter int OUT_W     = 16,
  localparam int STG      = $clog2(MAX_SHIFT + 1)
) (
  input  logic [ACC_W-1:0]   din,
  input  logic [SHIFT_W-1:0] code,
  output logic [OUT_W-1:0]   dout
);
  logic [STG-1:0]   amt;
  logic [ACC_W-1:0] stage [0:STG];

  always_comb begin
    if (code > SHIFT_W'(MAX_SHIFT)) amt = STG'(MAX_SHIFT);
    else                            amt = STG'(code);
  end

  assign stage[0] = din;

  for (genvar j = 0; j < STG; j++) begin : g_stage
    assign stage[j+1] = amt[j] ? (stage[j] >> (1 << j)) : stage[j];
  end

  assign dout = OUT_W'(stage[STG]);
endmodule

// File: rtl/ovs_status.sv
module ovs_status #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [OUT_W-1:0] res_in,
  input  logic             rd_strobe,
  input  logic             ovr_clr,
  input  logic             eoc_ie,
  input  logic             ovr_ie,
  output logic [OUT_W-1:0] result,
  output logic             result_valid,
  output logic             eoc_pulse,
  output logic             ovr_flag,
  output logic             irq
);
  logic [OUT_W-1:0] res_q, res_d;
  logic             val_q, val_d;
  logic             eoc_q, eoc_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    res_d = done ? res_in : res_q;
    eoc_d = done;

    if (done)           val_d = 1'b1;
    else if (rd_strobe) val_d = 1'b0;
    else                val_d = val_q;

    if (done && val_q && !rd_strobe) ovr_d = 1'b1;
    else if (ovr_clr)                ovr_d = 1'b0;
    else                             ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      val_q <= 1'b0;
      eoc_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      res_q <= res_d;
      val_q <= val_d;
      eoc_q <= eoc_d;
      ovr_q <= ovr_d;
    end
  end

  assign result       = res_q;
  assign result_valid = val_q;
  assign eoc_pulse    = eoc_q;
  assign ovr_flag     = ovr_q;
  assign irq          = (eoc_q & eoc_ie) | (ovr_q & ovr_ie);
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W  = OVS_SAMPLE_W,
  parameter int RESULT_W  = OVS_RESULT_W,
  parameter int RATIO_W   = OVS_RATIO_W,
  parameter int SHIFT_W   = OVS_SHIFT_W,
  parameter int MAX_SHIFT = OVS_MAX_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                clear,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [RATIO_W-1:0]  ratio_sel,
  input  logic [SHIFT_W-1:0]  shift_sel,
  input  logic                rd_strobe,
  input  logic                ovr_clr,
  input  logic                eoc_ie,
  input  logic                ovr_ie,
  output logic [RESULT_W-1:0] result,
  output logic                result_valid,
  output logic                eoc_pulse,
  output logic                ovr_flag,
  output logic                irq
);
  localparam int LOG_MAX = 1 << RATIO_W;
  localparam int ACC_W   = SAMPLE_W + LOG_MAX;

  logic                rst_s0, rst_sync_n;
  logic                take, first, last;
  logic [SHIFT_W-1:0]  shift_eff;
  logic [ACC_W-1:0]    sum;
  logic [RESULT_W-1:0] res_next;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  ovs_seq_ctrl #(.RATIO_W(RATIO_W), .SHIFT_W(SHIFT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .enable    (enable),
    .clear     (clear),
    .smp_valid (smp_valid),
    .ratio_in  (ratio_sel),
    .shift_in  (shift_sel),
    .take      (take),
    .first     (first),
    .last      (last),
    .shift_eff (shift_eff)
  );

  ovs_accum_dp #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .flush  (clear | ~enable),
    .take   (take),
    .first  (first),
    .sample (smp_data),
    .sum    (sum)
  );

  ovs_shifter #(
    .ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT), .OUT_W(RESULT_W)
  ) u_shift (
    .din  (sum),
    .code (shift_eff),
    .dout (res_next)
  );

  ovs_status #(.OUT_W(RESULT_W)) u_stat (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .done         (last),
    .res_in       (res_next),
    .rd_strobe    (rd_strobe),
    .ovr_clr      (ovr_clr),
    .eoc_ie       (eoc_ie),
    .ovr_ie       (ovr_ie),
    .result       (result),
    .result_valid (result_valid),
    .eoc_pulse    (eoc_pulse),
    .ovr_flag     (ovr_flag),
    .irq          (irq)
  );
endmodule

// File: rtl/ovs_accum_chk.sv
module ovs_accum_chk #(
  parameter int RESULT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                rd_strobe,
  input logic                ovr_clr,
  input logic                eoc_ie,
  input logic                ovr_ie,
  input logic [RESULT_W-1:0] result,
  input logic                result_valid,
  input logic                eoc_pulse,
  input logic                ovr_flag,
  input logic                irq
);
  p_eoc_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |=> !eoc_pulse);

  p_eoc_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> result_valid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(result_valid) |-> $past(rd_strobe));

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> eoc_pulse);

  p_no_eoc_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> !eoc_pulse);

  p_ovr_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> (eoc_pulse && $past(result_valid)));

  p_ovr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_flag) |-> $past(ovr_clr));

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_ie && !ovr_ie) |-> !irq);

  p_irq_eoc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_pulse && eoc_ie) |-> irq);
endmodule

bind ovs_accum ovs_accum_chk #(.RESULT_W(RESULT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .enable       (enable),
  .rd_strobe    (rd_strobe),
  .ovr_clr      (ovr_clr),
  .eoc_ie       (eoc_ie),
  .ovr_ie       (ovr_ie),
  .result       (result),
  .result_valid (result_valid),
  .eoc_pulse    (eoc_pulse),
  .ovr_flag     (ovr_flag),
  .irq          (irq)
);

// File: tb/ovs_accum_bench.sv
`timescale 1ns/1ps
module ovs_accum_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, clear, smp_valid;
  logic [11:0] smp_data;
  logic [2:0]  ratio_sel;
  logic [3:0]  shift_sel;
  logic        rd_strobe, ovr_clr, eoc_ie, ovr_ie;
  logic [15:0] result;
  logic        result_valid, eoc_pulse, ovr_flag, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ovs_accum u_ovs_accum (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .smp_valid(smp_valid), .smp_data(smp_data), .ratio_sel(ratio_sel),
    .shift_sel(shift_sel), .rd_strobe(rd_strobe), .ovr_clr(ovr_clr),
    .eoc_ie(eoc_ie), .ovr_ie(ovr_ie), .result(result),
    .result_valid(result_valid), .eoc_pulse(eoc_pulse),
    .ovr_flag(ovr_flag), .irq(irq)
  );

  // {ratio code, shift code, sample, expected result}
  localparam logic [34:0] VEC [0:9] = '{
    {3'd4, 4'd0,  12'hFFF, 16'hFFE0},  // R3 32x no shift
    {3'd7, 4'd0,  12'hFFF, 16'hFF00},  // R3 256x no shift, wraps
    {3'd4, 4'd4,  12'hFFF, 16'h1FFE},  // R3
    {3'd7, 4'd8,  12'hFFF, 16'h0FFF},  // R3
    {3'd0, 4'd1,  12'h123, 16'h0123},  // R2 2x
    {3'd5, 4'd6,  12'hFFF, 16'h0FFF},  // R3 64x
    {3'd7, 4'd12, 12'hFFF, 16'h0FFF},  // R4 reserved code
    {3'd2, 4'd15, 12'h800, 16'h0040},  // R4 reserved code
    {3'd6, 4'd2,  12'h001, 16'h0020},  // R3 128x
    {3'd3, 4'd0,  12'hABC, 16'hABC0}   // R2 16x
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive after an edge, return 1 ns after the next edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [11:0] v);
    smp_valid = 1'b1;
    smp_data  = v;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    tick();
    rd_strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; clear = 1'b0; smp_valid = 1'b0;
    smp_data = '0; ratio_sel = '0; shift_sel = '0; rd_strobe = 1'b0;
    ovr_clr = 1'b0; eoc_ie = 1'b0; ovr_ie = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 result", 32'(result), 32'h0);
    chk("R1 valid", 32'(result_valid), 32'h0);
    chk("R1 eoc", 32'(eoc_pulse), 32'h0);
    chk("R1 ovr", 32'(ovr_flag), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    enable = 1'b1;
    eoc_ie = 1'b1;

    // Table walk: R2, R3, R4, R7, R9, R10
    for (int v = 0; v < 10; v++) begin
      ratio_sel = VEC[v][34:32];
      shift_sel = VEC[v][31:28];
      for (int i = 0; i < (2 << VEC[v][34:32]); i++) begin
        push(VEC[v][27:16]);
        if (i == (2 << VEC[v][34:32]) - 2)
          chk("R2 no early eoc", 32'(eoc_pulse), 32'h0);
      end
      chk("R2 eoc at Nth sample", 32'(eoc_pulse), 32'h1);
      chk("R3/R4 result value", 32'(result), 32'(VEC[v][15:0]));
      chk("R7 valid set", 32'(result_valid), 32'h1);
      chk("R9 irq on eoc", 32'(irq), 32'h1);
      do_read();
      chk("R10 eoc one cycle", 32'(eoc_pulse), 32'h0);
      chk("R7 valid cleared by read", 32'(result_valid), 32'h0);
    end

    // R5 settings captured at start of sequence
    ratio_sel = 3'd1; shift_sel = 4'd0;
    push(12'h100);
    ratio_sel = 3'd0; shift_sel = 4'd3;
    push(12'h100);
    chk("R5 mid-change ratio ignored", 32'(eoc_pulse), 32'h0);
    push(12'h100);
    push(12'h100);
    chk("R5 old ratio eoc", 32'(eoc_pulse), 32'h1);
    chk("R5 old shift result", 32'(result), 32'h400);
    do_read();
    push(12'h100);
    push(12'h100);
    chk("R5 new settings result", 32'(result), 32'h40);
    chk("R5 new ratio eoc", 32'(eoc_pulse), 32'h1);
    do_read();

    // R6 disabled samples ignored, result kept
    enable = 1'b0;
    for (int i = 0; i < 5; i++) push(12'hFFF);
    chk("R6 no eoc while disabled", 32'(eoc_pulse), 32'h0);
    chk("R6 result kept while disabled", 32'(result), 32'h40);
    enable = 1'b1;
    ratio_sel = 3'd0; shift_sel = 4'd0;
    push(12'h010);
    push(12'h020);
    chk("R6 sum after re-enable", 32'(result), 32'h30);
    do_read();

    // R6 clear discards partial sum
    ratio_sel = 3'd2;
    for (int i = 0; i < 3; i++) push(12'hFFF);
    clear = 1'b1;
    tick();
    clear = 1'b0;
    chk("R6 result kept after clear", 32'(result), 32'h30);
    chk("R6 no eoc after clear", 32'(eoc_pulse), 32'h0);
    for (int i = 0; i < 7; i++) push(12'h001);
    chk("R6 count restarted", 32'(eoc_pulse), 32'h0);
    push(12'h001);
    chk("R6 fresh sum", 32'(result), 32'h8);
    do_read();

    // R7/R8 read on the completing edge: valid stays, no overflow
    ratio_sel = 3'd0;
    push(12'h001);
    push(12'h001);
    smp_valid = 1'b1; smp_data = 12'h002; tick();
    smp_data = 12'h002; rd_strobe = 1'b1; tick();
    smp_valid = 1'b0; rd_strobe = 1'b0;
    chk("R7 set wins over read", 32'(result_valid), 32'h1);
    chk("R8 no ovr when read same edge", 32'(ovr_flag), 32'h0);
    chk("R3 2x sum", 32'(result), 32'h4);

    // R8 overwrite unread result
    eoc_ie = 1'b0; ovr_ie = 1'b1;
    push(12'h003);
    push(12'h003);
    chk("R8 ovr set on overwrite", 32'(ovr_flag), 32'h1);
    chk("R9 irq from ovr", 32'(irq), 32'h1);
    tick();
    chk("R8 ovr sticky", 32'(ovr_flag), 32'h1);
    ovr_ie = 1'b0;
    #0.5;
    chk("R9 irq masked", 32'(irq), 32'h0);
    ovr_clr = 1'b1;
    tick();
    ovr_clr = 1'b0;
    chk("R8 ovr cleared by write 1", 32'(ovr_flag), 32'h0);
    // R8 set wins over clear on the same edge (valid still set)
    push(12'h001);
    smp_valid = 1'b1; smp_data = 12'h001; ovr_clr = 1'b1; tick();
    smp_valid = 1'b0; ovr_clr = 1'b0;
    chk("R8 set wins over clear", 32'(ovr_flag), 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule